// File: doc/BRIEF.md
# Frame-Checked SPI Register Target

This block is the target side of an SPI register port. It runs on a fast system clock and oversamples the serial pins. SCLK, CS_n and MOSI each pass through a two-stage synchronizer, and edge detectors turn the synchronized SCLK and CS_n into single-cycle edge pulses. While chip select is low, each SCLK falling edge latches one MOSI bit into a shift register. When chip select returns high, the block checks the frame. It runs only the last 24-bit command word, and only if the edge counts show whole words and a clean ending. Otherwise it throws the frame away. Because only the last word counts, several targets can sit in one chain.

Reads are split across two frames. A valid read frame captures the addressed register into a response word. The next frame shifts that word out on MISO, most significant bit first. Any frame that is not a valid read leaves nothing behind, so the frame after it returns zeros. The register space holds a few writable 16-bit registers and a fixed, read-only identification register. The serial side has no back-pressure: the controller owns SCLK, and the target keeps pace because the system clock is at least eight times faster than SCLK.

Top module: `spi_frame_target`

## Requirements
- R1: A command word is 24 bits, sent MSB first. Bit 23 selects read (1) or write (0), bits 22:16 hold a 7-bit register address, and bits 15:0 hold write data. MOSI is captured on each SCLK falling edge while CS_n is low.
- R2: When CS_n rises, a frame is executed only if its falling-edge count is 24×N with N ≥ 1. Only the last 24 bits shifted in are executed; earlier words in the same frame have no effect.
- R3: A frame whose falling-edge count is not a multiple of 24 is rejected. No register changes, and the following frame returns zeros.
- R4: SCLK idles high. A SCLK rising edge after the last falling edge, while CS_n is still low, voids the frame: a frame is accepted only if its rising-edge count is one less than its falling-edge count. A voided write changes nothing, and a voided read arms no data.
- R5: After a valid read of address A, the next frame shifts out the response {1'b0, A[6:0], data[15:0]} on MISO, MSB first. The first bit is present before the first falling edge, and MISO advances on each SCLK rising edge. A frame that follows a write, a rejected frame or reset returns all zeros.
- R6: MISO is low whenever CS_n is high.
- R7: Addresses 0x00 to 0x03 are writable 16-bit registers that reset to 0x0000.
- R8: Address 0x6C always reads 0x1220. Writes to 0x6C or to any unmapped address are ignored, and reads of unmapped addresses return 0x0000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the SCLK rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the controller, idles high |
| cs_n | input | 1 | Active-low chip select |
| mosi | input | 1 | Serial data from the controller |
| miso | output | 1 | Serial data to the controller |

## Verification
The hardest case to reach from the pins is a frame that ends with a stray SCLK rise. Such a frame has exactly 24 falling edges, but the final rising edge lands before CS_n goes high. It must be discarded even though its bit count looks correct. The bench's transfer task controls the phase of the last clock edge against CS_n, so the same command can end cleanly or with that early rise. The effect is then read back through the two-frame read path: register contents and the zero response that should follow. The bench also sends frames one bit short, one bit long and two words long, to separate the word-count check from the edge-balance check.

// File: rtl/spi_frame_pkg.sv
package spi_frame_pkg;
  localparam int WORD_W = 24;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 16;
  localparam int CNT_W  = $clog2(WORD_W);

  typedef struct packed {
    logic              rd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } cmd_word_t;
endpackage

// File: rtl/spi_sync_edge.sv
module spi_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic sclk_rise,
  output logic sclk_fall,
  output logic cs_fall,
  output logic cs_rise,
  output logic cs_low,
  output logic mosi_s
);
  localparam int NSIG = 3;
  localparam logic [NSIG-1:0] RST_VAL = 3'b011;  // {mosi, cs_n, sclk}

  logic [NSIG-1:0] raw_in;
  logic [NSIG-1:0] synced;
  logic [1:0]      prev_q;   // {cs_n, sclk} one cycle later

  assign raw_in = {mosi, cs_n, sclk};

  for (genvar g = 0; g < NSIG; g++) begin : g_sync
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], raw_in[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= RST_VAL[1:0];
    else        prev_q <= synced[1:0];
  end

  assign sclk_rise = ~prev_q[0] &  synced[0];
  assign sclk_fall =  prev_q[0] & ~synced[0];
  assign cs_fall   =  prev_q[1] & ~synced[1];
  assign cs_rise   = ~prev_q[1] &  synced[1];
  assign cs_low    = ~synced[1];
  assign mosi_s    =  synced[2];
endmodule

// File: rtl/spi_frame_rx.sv
module spi_frame_rx
  import spi_frame_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_rise,
  input  logic      sclk_fall,
  input  logic      cs_fall,
  input  logic      cs_rise,
  input  logic      cs_low,
  input  logic      mosi_s,
  output logic      commit,
  output cmd_word_t cmd
);
  logic [WORD_W-1:0] shreg_q;
  logic [CNT_W-1:0]  bit_idx_q;
  logic              word_seen_q;
  logic              fall_open_q;  // last edge in window was a fall
  logic              void_q;       // rise with no preceding fall

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q     <= '0;
      bit_idx_q   <= '0;
      word_seen_q <= 1'b0;
      fall_open_q <= 1'b0;
      void_q      <= 1'b0;
    end else if (cs_fall) begin
      bit_idx_q   <= '0;
      word_seen_q <= 1'b0;
      fall_open_q <= 1'b0;
      void_q      <= 1'b0;
    end else if (cs_low) begin
      if (sclk_fall) begin
        shreg_q     <= {shreg_q[WORD_W-2:0], mosi_s};
        fall_open_q <= 1'b1;
        if (bit_idx_q == CNT_W'(WORD_W - 1)) begin
          bit_idx_q   <= '0;
          word_seen_q <= 1'b1;
        end else begin
          bit_idx_q <= bit_idx_q + 1'b1;
        end
      end
      if (sclk_rise) begin
        if (!fall_open_q) void_q <= 1'b1;
        fall_open_q <= 1'b0;
      end
    end
  end

  assign commit = cs_rise && (bit_idx_q == '0) && word_seen_q && fall_open_q && !void_q;
  assign cmd    = cmd_word_t'(shreg_q);

  AST_BIT_IDX_IN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    bit_idx_q < CNT_W'(WORD_W)); // R2
  AST_WHOLE_WORD_AT_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_low && sclk_fall && bit_idx_q != CNT_W'(WORD_W - 1)) |=> !commit); // R3
endmodule

// File: rtl/spi_reg_bank.sv
module spi_reg_bank
  import spi_frame_pkg::*;
#(
  parameter int                 NUM_REGS = 4,
  parameter logic [ADDR_W-1:0]  ID_ADDR  = 7'h6C,
  parameter logic [DATA_W-1:0]  ID_VALUE = 16'h1220
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs_q <= '0;
    end else if (wr_en) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        if (addr == ADDR_W'(i)) regs_q[i] <= wr_data;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (addr == ID_ADDR) rd_data = ID_VALUE;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (addr == ADDR_W'(i)) rd_data = regs_q[i];
    end
  end

  AST_REGS_HOLD_WITHOUT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q)); // R3
endmodule

// File: rtl/spi_frame_target.sv
module spi_frame_target
  import spi_frame_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter int                NUM_REGS    = 4,
  parameter logic [ADDR_W-1:0] ID_ADDR     = 7'h6C,
  parameter logic [DATA_W-1:0] ID_VALUE    = 16'h1220
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic mosi,
  output logic miso
);
  logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_low, mosi_s;
  logic              commit;
  cmd_word_t         cmd;
  logic [DATA_W-1:0] rd_data;
  logic [WORD_W-1:0] resp_q;
  logic [WORD_W-1:0] out_sr_q;

  spi_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .sclk_rise(sclk_rise), .sclk_fall(sclk_fall), .cs_fall(cs_fall),
    .cs_rise(cs_rise), .cs_low(cs_low), .mosi_s(mosi_s)
  );

  spi_frame_rx u_rx (
    .clk(clk), .rst_n(rst_n), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_low(cs_low), .mosi_s(mosi_s),
    .commit(commit), .cmd(cmd)
  );

  spi_reg_bank #(.NUM_REGS(NUM_REGS), .ID_ADDR(ID_ADDR), .ID_VALUE(ID_VALUE)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(commit && !cmd.rd), .addr(cmd.addr),
    .wr_data(cmd.data), .rd_data(rd_data)
  );

  // Response armed at the end of a frame, consumed by the next one.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       resp_q <= '0;
    else if (commit)  resp_q <= cmd.rd ? {1'b0, cmd.addr, rd_data} : '0;
    else if (cs_rise) resp_q <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      out_sr_q <= '0;
    else if (cs_fall)                out_sr_q <= resp_q;
    else if (cs_low && sclk_rise)    out_sr_q <= {out_sr_q[WORD_W-2:0], 1'b0};
  end

  assign miso = cs_low & out_sr_q[WORD_W-1];

  AST_COMMIT_ONLY_AT_CS_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> cs_rise); // R2
  AST_REJECT_LEAVES_NO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_rise && !commit) |=> resp_q == '0); // R4
  AST_MISO_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3)) |-> !miso); // R6
endmodule

// File: tb/spi_frame_target_tb.sv
module spi_frame_target_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sclk = 1'b1;
  logic cs_n = 1'b1;
  logic mosi = 1'b0;
  logic miso;
  int   n_checks = 0;
  int   n_fails = 0;
  bit   done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  spi_frame_target u_dut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  // {command sent, response expected on MISO during that same frame}
  localparam logic [47:0] VEC [12] = '{
    {24'h00A5A5, 24'h000000},  // write r0; nothing armed after reset
    {24'h800000, 24'h000000},  // read r0; prior frame was a write
    {24'h011234, 24'h00A5A5},  // write r1; returns r0
    {24'hEC0000, 24'h000000},  // read ID
    {24'h810000, 24'h6C1220},  // read r1; returns ID
    {24'h6CFFFF, 24'h011234},  // write ID (ignored)
    {24'hEC0000, 24'h000000},  // read ID again
    {24'h900000, 24'h6C1220},  // read unmapped; ID unchanged
    {24'h830000, 24'h100000},  // read r3; unmapped reads zero
    {24'h03BEEF, 24'h030000},  // write r3; r3 was reset value
    {24'h830000, 24'h000000},  // read r3
    {24'h820000, 24'h03BEEF}   // read r2; returns r3
  };

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // Sends n bits MSB first; early=1 puts a final SCLK rise before CS_n rises.
  task automatic spi_xfer(input logic [47:0] bits, input int n, input bit early,
                          output logic [23:0] got);
    got = '0;
    cs_n = 1'b0;
    #100;
    for (int i = n - 1; i >= 0; i--) begin
      mosi = bits[i];
      #40;
      if (n - 1 - i < 24) got = {got[22:0], miso};
      sclk = 1'b0;
      #80;
      if (i > 0 || early) begin
        sclk = 1'b1;
        #40;
      end
    end
    if (early) begin
      #40;
      cs_n = 1'b1;
    end else begin
      #20;
      cs_n = 1'b1;
      #40;
      sclk = 1'b1;
    end
    #200;
  endtask

  initial begin
    logic [23:0] got;
    repeat (10) @(posedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R6 reset idle", {23'd0, miso}, 24'd0);

    for (int k = 0; k < 12; k++) begin
      spi_xfer({24'd0, VEC[k][47:24]}, 24, 1'b0, got);
      check($sformatf("R5/R7/R8 table entry %0d", k), got, VEC[k][23:0]);
    end
    #50;
    check("R6 idle after armed read", {23'd0, miso}, 24'd0);

    // R4: early final rise voids read and write
    spi_xfer({24'd0, 24'h830000}, 24, 1'b1, got);
    check("R7 r2 reset value", got, 24'h020000);
    spi_xfer({24'd0, 24'h800000}, 24, 1'b0, got);
    check("R4 voided read arms nothing", got, 24'h000000);
    spi_xfer({24'd0, 24'h001111}, 24, 1'b1, got);
    check("R5 read r0", got, 24'h00A5A5);
    spi_xfer({24'd0, 24'h800000}, 24, 1'b0, got);
    check("R4 zeros after voided write", got, 24'h000000);
    spi_xfer({24'd0, 24'h810000}, 24, 1'b0, got);
    check("R4 voided write left r0", got, 24'h00A5A5);

    // R3: one bit short, one bit long
    spi_xfer({24'd0, 24'h010000}, 23, 1'b0, got);
    check("R3 short frame shifts response", got, 24'h00891A);
    spi_xfer({24'd0, 24'h810000}, 24, 1'b0, got);
    check("R3 zeros after short frame", got, 24'h000000);
    spi_xfer({23'd0, 25'h0010000}, 25, 1'b0, got);
    check("R5 read r1 before long frame", got, 24'h011234);
    spi_xfer({24'd0, 24'h810000}, 24, 1'b0, got);
    check("R3 zeros after long frame", got, 24'h000000);
    spi_xfer({24'd0, 24'h800000}, 24, 1'b0, got);
    check("R3 r1 unchanged", got, 24'h011234);

    // R2: two-word frame, only last word runs
    spi_xfer({24'h027777, 24'h024242}, 48, 1'b0, got);
    check("R2 first bits of chained frame", got, 24'h00A5A5);
    spi_xfer({24'd0, 24'h800000}, 24, 1'b0, got);
    check("R2 chained write not a read", got, 24'h000000);
    spi_xfer({24'd0, 24'h820000}, 24, 1'b0, got);
    check("R1 r0 intact", got, 24'h00A5A5);
    spi_xfer({24'h007777, 24'hEC0000}, 48, 1'b0, got);
    check("R2 last word written", got, 24'h024242);
    spi_xfer({24'd0, 24'h800000}, 24, 1'b0, got);
    check("R2 chained read returns ID", got, 24'h6C1220);
    spi_xfer({24'd0, 24'h800000}, 24, 1'b0, got);
    check("R2 earlier word not executed", got, 24'h00A5A5);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end
endmodule